// File: doc/BRIEF.md
# Serial Instruction Loader and Decoder

This block sits between a three-wire serial host link and the column store of a small dot-matrix display of four digits by seven rows of five dots. The host lowers an active-low frame strobe, shifts one byte least-significant bit first on the rising edges of a shift clock, and raises the strobe again. At that rising edge the block splits the byte into a 3-bit operation code (bits 7..5) and a 5-bit payload (bits 4..0). Depending on the code, it selects a digit, stores one row of column dots, loads the 5-bit control word, or clears the store.

All three serial pins pass through two-stage synchronisers into the system clock domain, and both edges are detected there. Row data goes out on a registered write port with digit, row, dots and a one-cycle enable. The downstream store shares the block's asynchronous reset. A software clear is sent to that store as a sweep of 28 zero writes, and the write port shows every one of them.

The decoder is a two-state machine. In `ST_IDLE` it decodes each completed frame. The transition `ST_IDLE -> ST_SWEEP` happens on a clear code. The transition `ST_SWEEP -> ST_IDLE` happens once digit 3 row 6 has been written with zero. Any frame that completes while the machine is in `ST_SWEEP` is discarded.

Top module: `serin_decode`

## Requirements
- R1: While the frame strobe is high, rising edges of the shift clock leave the shift register unchanged. While it is low, each rising edge shifts the data pin in at bit 7 and moves the older bits toward bit 0, so the first bit sent ends in bit 0.
- R2: A rising edge of the frame strobe decodes the shift register. Bits 7..5 are the operation code and bits 4..0 are the payload.
- R3: Code 000 produces exactly one write-enable cycle at the current digit and row pointer, with wr_cols equal to the payload. wr_cols[4] is the leftmost dot (column 0) and wr_cols[0] is column 4.
- R4: After each row write the row pointer advances by one. After row 6 it wraps to row 0.
- R5: Code 101 sets the digit pointer to payload bits 1..0, ignores payload bits 4..2, and sets the row pointer to 0.
- R6: Code 110 writes zero to all 28 locations, digit-major with rows 0 to 6 within each digit. It then leaves both the digit and row pointers at 0, and it does not change the control word.
- R7: Code 111 loads ctrl_word with the payload, arranged as {prescale, current-reduce, level[2:0]}.
- R8: Codes 001, 010, 011 and 100 cause no write and change neither the control word nor the pointers.
- R9: A frame with fewer or more than eight shift edges is still decoded, using whatever the shift register holds when the strobe rises.
- R10: An asynchronous low reset clears the control word (0 means full brightness with no prescale), the digit and row pointers and the shift register, and it deasserts the write enable.
- R11: A frame that completes during a clear sweep is discarded, and the sweep runs to the end unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_load_n | input | 1 | Frame strobe, active low; its rising edge decodes the frame |
| wr_en | output | 1 | One-cycle store write enable |
| wr_digit | output | 2 | Digit being written |
| wr_row | output | 3 | Row being written (0 to 6) |
| wr_cols | output | 5 | Dot data; bit 4 is column 0 |
| ctrl_word | output | 5 | Control word {prescale, current-reduce, level[2:0]} |

## Verification
The clear sweep and the decoding of a new frame can both fall in the same cycle, because a short frame can finish inside the 28-cycle sweep. The bench provokes this by sending a clear frame and, two cycles later, a three-bit frame whose final register value decodes as a nonzero row write. The result is judged on two points. First, the write count rises by exactly 28. Second, the shadow copy of the store is all zero. A following zero-length frame then re-decodes the same register value, which shows that the frame was dropped and the shift register was left intact.

// File: rtl/serin_pkg.sv
package serin_pkg;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 3;
    localparam int PAY_W  = BYTE_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_COLS  = 3'b000,
        OP_ADDR  = 3'b101,
        OP_CLEAR = 3'b110,
        OP_CTRL  = 3'b111
    } opcode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } state_e;
endpackage

// File: rtl/serin_sync.sv
module serin_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= {2{RST_VAL[b]}};
            else        stage <= {stage[0], d[b]};
        end
        assign q[b] = stage[1];
    end
endmodule

// File: rtl/serin_shifter.sv
module serin_shifter
    import serin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_s,
    input  logic              sclk_s,
    input  logic              load_s,
    output logic [BYTE_W-1:0] frame_o,
    output logic              stb_o
);
    logic              sclk_q;
    logic              load_q;
    logic [BYTE_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            load_q <= 1'b1;
            sreg   <= '0;
        end else begin
            sclk_q <= sclk_s;
            load_q <= load_s;
            if (sclk_s && !sclk_q && !load_s)
                sreg <= {data_s, sreg[BYTE_W-1:1]};
        end
    end

    assign stb_o   = load_s && !load_q;
    assign frame_o = sreg;
endmodule

// File: rtl/serin_decoder.sv
module serin_decoder
    import serin_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int ROWS   = 7,
    localparam int DIG_W = $clog2(DIGITS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [BYTE_W-1:0] frame_i,
    output logic              wr_en_o,
    output logic [DIG_W-1:0]  wr_digit_o,
    output logic [ROW_W-1:0]  wr_row_o,
    output logic [PAY_W-1:0]  wr_cols_o,
    output logic              clr_wr_o,
    output logic [PAY_W-1:0]  ctrl_o
);
    state_e           state, state_nx;
    opcode_e          op;
    logic [PAY_W-1:0] payload;
    logic [DIG_W-1:0] dig_q, swp_dig;
    logic [ROW_W-1:0] row_q, swp_row;
    logic             swp_last;

    assign op       = opcode_e'(frame_i[BYTE_W-1 -: OP_W]);
    assign payload  = frame_i[PAY_W-1:0];
    assign swp_last = (swp_dig == DIG_W'(DIGITS-1)) && (swp_row == ROW_W'(ROWS-1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (stb_i && op == OP_CLEAR) state_nx = ST_SWEEP;
            ST_SWEEP: if (swp_last)                state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o    <= 1'b0;
            clr_wr_o   <= 1'b0;
            wr_digit_o <= '0;
            wr_row_o   <= '0;
            wr_cols_o  <= '0;
            ctrl_o     <= '0;
            dig_q      <= '0;
            row_q      <= '0;
            swp_dig    <= '0;
            swp_row    <= '0;
        end else begin
            wr_en_o  <= 1'b0;
            clr_wr_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (stb_i) begin
                        case (op)
                            OP_COLS: begin
                                wr_en_o    <= 1'b1;
                                wr_digit_o <= dig_q;
                                wr_row_o   <= row_q;
                                wr_cols_o  <= payload;
                                row_q      <= (row_q == ROW_W'(ROWS-1)) ? '0 : row_q + ROW_W'(1);
                            end
                            OP_ADDR: begin
                                dig_q <= payload[DIG_W-1:0];
                                row_q <= '0;
                            end
                            OP_CLEAR: begin
                                dig_q   <= '0;
                                row_q   <= '0;
                                swp_dig <= '0;
                                swp_row <= '0;
                            end
                            OP_CTRL: ctrl_o <= payload;
                            default: ;
                        endcase
                    end
                end
                ST_SWEEP: begin
                    wr_en_o    <= 1'b1;
                    clr_wr_o   <= 1'b1;
                    wr_digit_o <= swp_dig;
                    wr_row_o   <= swp_row;
                    wr_cols_o  <= '0;
                    if (swp_row == ROW_W'(ROWS-1)) begin
                        swp_row <= '0;
                        swp_dig <= swp_dig + DIG_W'(1);
                    end else begin
                        swp_row <= swp_row + ROW_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/serin_decode.sv
module serin_decode
    import serin_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int ROWS   = 7,
    localparam int DIG_W = $clog2(DIGITS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             ser_load_n,
    output logic             wr_en,
    output logic [DIG_W-1:0] wr_digit,
    output logic [ROW_W-1:0] wr_row,
    output logic [PAY_W-1:0] wr_cols,
    output logic [PAY_W-1:0] ctrl_word
);
    logic [2:0]        pins_s;
    logic [BYTE_W-1:0] frame;
    logic              byte_stb;
    logic              clr_wr;

    serin_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_load_n, ser_clk, ser_data}),
        .q     (pins_s)
    );

    serin_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_s  (pins_s[0]),
        .sclk_s  (pins_s[1]),
        .load_s  (pins_s[2]),
        .frame_o (frame),
        .stb_o   (byte_stb)
    );

    serin_decoder #(.DIGITS(DIGITS), .ROWS(ROWS)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (byte_stb),
        .frame_i    (frame),
        .wr_en_o    (wr_en),
        .wr_digit_o (wr_digit),
        .wr_row_o   (wr_row),
        .wr_cols_o  (wr_cols),
        .clr_wr_o   (clr_wr),
        .ctrl_o     (ctrl_word)
    );
endmodule

// File: rtl/serin_decode_chk.sv
module serin_decode_chk #(
    parameter int DIGITS = 4,
    parameter int ROWS   = 7,
    localparam int DIG_W = $clog2(DIGITS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_stb,
    input logic             clr_wr,
    input logic             wr_en,
    input logic [DIG_W-1:0] wr_digit,
    input logic [ROW_W-1:0] wr_row,
    input logic [4:0]       wr_cols,
    input logic [4:0]       ctrl_word
);
    // R4: the row pointer never leaves the 0..ROWS-1 range on the port
    p_row_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_row <= ROW_W'(ROWS-1)));

    // R3: a row write lasts one cycle
    p_one_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_wr) |=> !wr_en);

    // R6: a clear sweep starts at digit 0 row 0 with zero dots
    p_sweep_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_wr) |-> (wr_digit == '0 && wr_row == '0 && wr_cols == '0));

    // R7: the control word changes only after a decoded frame
    p_ctrl_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> $past(byte_stb));

    // R8: a row write outside a sweep is always caused by a decoded frame
    p_write_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_wr) |-> $past(byte_stb));
endmodule

bind serin_decode serin_decode_chk #(.DIGITS(DIGITS), .ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_stb  (byte_stb),
    .clr_wr    (clr_wr),
    .wr_en     (wr_en),
    .wr_digit  (wr_digit),
    .wr_row    (wr_row),
    .wr_cols   (wr_cols),
    .ctrl_word (ctrl_word)
);

// File: tb/serin_decode_test.sv
module serin_decode_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_load_n = 1'b1;
    logic       wr_en;
    logic [1:0] wr_digit;
    logic [2:0] wr_row;
    logic [4:0] wr_cols;
    logic [4:0] ctrl_word;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [4:0] shadow [4][7];
    int         wr_count = 0;
    int         last_dig = -1;
    int         last_row = -1;

    logic [4:0] exp_mem [4][7];
    logic [7:0] exp_sr = 8'h00;
    logic [4:0] exp_ctrl = 5'h00;
    int         exp_dig = 0;
    int         exp_row = 0;
    int         exp_writes = 0;

    serin_decode uut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_load_n(ser_load_n), .wr_en(wr_en), .wr_digit(wr_digit),
        .wr_row(wr_row), .wr_cols(wr_cols), .ctrl_word(ctrl_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            shadow[wr_digit][wr_row] = wr_cols;
            wr_count = wr_count + 1;
            last_dig = int'(wr_digit);
            last_row = int'(wr_row);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_models();
        for (int d = 0; d < 4; d++)
            for (int r = 0; r < 7; r++) begin
                shadow[d][r]  = 5'h00;
                exp_mem[d][r] = 5'h00;
            end
        wr_count = 0; exp_writes = 0; exp_sr = 8'h00; exp_ctrl = 5'h00;
        exp_dig = 0; exp_row = 0; last_dig = -1; last_row = -1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_models();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // send the low nbits of v (bit 0 first); extra bits repeat the pattern
    task automatic send_frame(input logic [7:0] v, input int nbits, input int gap);
        ser_load_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_data = v[i % 8];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            exp_sr = {v[i % 8], exp_sr[7:1]};
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (2) @(negedge clk);
        ser_load_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic model_decode();
        logic [4:0] pay;
        pay = exp_sr[4:0];
        case (exp_sr[7:5])
            3'b000: begin
                exp_mem[exp_dig][exp_row] = pay;
                exp_writes++;
                exp_row = (exp_row == 6) ? 0 : exp_row + 1;
            end
            3'b101: begin exp_dig = int'(pay[1:0]); exp_row = 0; end
            3'b110: begin
                for (int d = 0; d < 4; d++)
                    for (int r = 0; r < 7; r++) exp_mem[d][r] = 5'h00;
                exp_writes += 28; exp_dig = 0; exp_row = 0;
            end
            3'b111: exp_ctrl = pay;
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        int bad;
        int first_a;
        int first_e;
        bad = 0; first_a = 0; first_e = 0;
        for (int d = 0; d < 4; d++)
            for (int r = 0; r < 7; r++)
                if (shadow[d][r] !== exp_mem[d][r]) begin
                    if (bad == 0) begin first_a = shadow[d][r]; first_e = exp_mem[d][r]; end
                    bad++;
                end
        check(bad == 0, req, "store contents", first_a, first_e);
        check(ctrl_word === exp_ctrl, req, "ctrl_word", ctrl_word, exp_ctrl);
        check(wr_count == exp_writes, req, "write count", wr_count, exp_writes);
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R2 R3 R4";
            3'b101:  return "R2 R5";
            3'b110:  return "R2 R6";
            3'b111:  return "R2 R7";
            default: return "R2 R8";
        endcase
    endfunction

    initial begin
        clear_models();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: state after reset
        check(wr_en === 1'b0, "R10", "wr_en after reset", wr_en, 0);
        check(ctrl_word === 5'h00, "R10", "ctrl_word after reset", ctrl_word, 0);

        // sweep of every byte value, full eight-bit frames
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), 8, (v[7:5] == 3'b110) ? 40 : 12);
            model_decode();
            compare(tag_of(v[7:5]));
        end

        // R4: nine writes into digit 2 wrap the pointer back to row 0
        send_frame(8'hA2, 8, 12); model_decode();
        for (int k = 0; k < 9; k++) begin
            send_frame(8'(k + 3), 8, 12);
            model_decode();
        end
        compare("R4");
        check(last_dig == 2 && last_row == 1, "R4", "last write row", last_row, 1);
        check(shadow[2][0] === 5'h0A, "R4", "row 0 overwritten after wrap", shadow[2][0], 5'h0A);

        // R1: shift edges while the strobe is high do nothing
        send_frame(8'hE5, 8, 12); model_decode();
        ser_data = 1'b1;
        for (int k = 0; k < 3; k++) begin
            repeat (2) @(negedge clk); ser_clk = 1'b1;
            repeat (2) @(negedge clk); ser_clk = 1'b0;
        end
        ser_data = 1'b0;
        send_frame(8'h00, 0, 12); model_decode();
        check(ctrl_word === 5'h05, "R1", "ctrl after edges with strobe high", ctrl_word, 5'h05);
        compare("R1");

        // R9: short and long frames
        send_frame(8'h02, 3, 12); model_decode();
        compare("R9 short");
        send_frame(8'h3D, 11, 12); model_decode();
        compare("R9 long");

        // R11: a short frame finishing inside a clear sweep is dropped
        send_frame(8'hC0, 8, 2); model_decode();
        send_frame(8'h00, 3, 40);
        check(exp_sr == 8'h18, "R11", "bench shift model", exp_sr, 8'h18);
        compare("R11");
        send_frame(8'h00, 0, 12); model_decode();
        compare("R11 R9 re-decode");
        check(last_dig == 0 && last_row == 0, "R11", "re-decoded write location", last_row, 0);

        // R10: mid-run reset clears control word, pointers and shift register
        send_frame(8'hE3, 8, 12); model_decode();
        send_frame(8'hA3, 8, 12); model_decode();
        send_frame(8'h1F, 8, 12); model_decode();
        compare("R10 pre");
        do_reset();
        check(ctrl_word === 5'h00, "R10", "ctrl_word after mid reset", ctrl_word, 0);
        send_frame(8'h00, 0, 12); model_decode();
        check(wr_count == 1, "R10", "writes after empty frame", wr_count, 1);
        check(last_dig == 0 && last_row == 0, "R10", "write location after reset", last_dig * 8 + last_row, 0);
        compare("R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule